// File: doc/BRIEF.md
# Periodic Split Transaction Scheduler

This block sequences split transactions for one periodic interrupt endpoint. The endpoint is full- or low-speed and sits behind a transaction translator on a high-speed bus. The queue traversal logic gives the block a visit strobe once per microframe. With the strobe come the endpoint's start and completion masks, its direction and its byte count, together with the low bits of the frame index. On a visit the block decides whether to launch a start-split or a complete-split this microframe, or neither. It keeps the tracking fields of the split between visits: the frame tag, the completion progress vector and the error budget.

After a complete-split goes out, the block waits for the translator's handshake. The handshake either ends the split, asks for another completion attempt in a later microframe, or counts as a failure. A failure uses up one unit of the error budget. When the budget runs out the block stops scheduling until it is reset.

There are four states. DO_START waits for a microframe picked by the start mask. DO_COMPLETE runs three completion tests on every visit. AWAIT_HS waits for the translator's answer. HALTED is entered when the budget reaches zero. The transitions are:
- DO_START to DO_COMPLETE when a start-split is issued.
- DO_COMPLETE to AWAIT_HS when a complete-split is issued.
- AWAIT_HS to DO_COMPLETE on a retry.
- AWAIT_HS to DO_START on success or on a failure that leaves budget.
- AWAIT_HS to HALTED on a failure that empties the budget.
- HALTED leaves only through reset.

Top module: `psplit_ctrl`

## Requirements
- R1: The microframe bit is the one-hot decode of `fr_idx[2:0]`. In DO_START, a visit whose microframe bit meets a set bit of `s_mask` pulses `ss_go` for one cycle, in the cycle after the visit, and moves to DO_COMPLETE. With no overlap, nothing is issued.
- R2: On a start-split, `s_bytes_out` becomes 0 when `dir_in` is 1 (IN) and becomes `s_bytes_in` when `dir_in` is 0 (OUT). Otherwise `s_bytes_out` holds.
- R3: On a start-split, `frame_tag` takes `fr_idx[7:3]` and `c_prog` is cleared to 0.
- R4: Issuing a start-split or a complete-split leaves `cerr` unchanged.
- R5: In DO_COMPLETE, a visit issues a complete-split only when three tests all pass. Test A: the microframe bit meets a set bit of `c_mask`. Test B: `frame_tag` equals `fr_idx[7:3]`. Test C: for the previous microframe bit, any set `c_mask` bit there is also set in `c_prog`. The issue pulses `cs_go` one cycle after the visit, ORs the microframe bit into `c_prog`, and moves to AWAIT_HS.
- R6: The previous microframe bit is the current one rotated right by one, so microframe 0 checks bit 7.
- R7: A visit in DO_COMPLETE where Test A passes and Test B or Test C fails pulses `split_err`. The state, `c_prog` and `cerr` are left unchanged.
- R8: The handshake codes are NAK=0, ACK=1, DATA=2, ERR=3 and NYET=4. NAK returns the block to DO_COMPLETE. ACK on an OUT split or DATA on an IN split pulses `split_done` and returns the block to DO_START.
- R9: The following are failures: ERR; NYET on the last complete-split (no `c_mask` bit above the issuing microframe); ACK on IN; DATA on OUT; and codes 5 to 7. A failure decrements `cerr` and returns the block to DO_START. NYET on a complete-split that is not the last returns the block to DO_COMPLETE with `cerr` unchanged.
- R10: A failure that brings `cerr` to 0 enters HALTED. In HALTED no split is issued until reset.
- R11: A visit during AWAIT_HS, and a handshake in any other state, have no effect.
- R12: After reset all pulses are low, `frame_tag`, `c_prog` and `s_bytes_out` are 0, and `cerr` equals `CERR_INIT`.
- R13: At most one of `ss_go`, `cs_go`, `split_err` and `split_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| visit | input | 1 | Queue head visited this microframe |
| fr_idx | input | $clog2(UF_N)+TAG_W | Frame index: microframe in low bits, frame above |
| s_mask | input | UF_N | Start-split microframe mask |
| c_mask | input | UF_N | Complete-split microframe mask |
| dir_in | input | 1 | 1 = IN transfer, 0 = OUT |
| s_bytes_in | input | SB_W | Byte count from the queue head |
| hs_valid | input | 1 | Translator handshake present |
| hs_code | input | 3 | Handshake code |
| ss_go | output | 1 | Start-split issue pulse |
| cs_go | output | 1 | Complete-split issue pulse |
| split_err | output | 1 | Test B or C failure pulse |
| split_done | output | 1 | Split completed pulse |
| frame_tag | output | TAG_W | Stored expected frame |
| c_prog | output | UF_N | Complete-split progress vector |
| cerr | output | CERR_W | Remaining error budget |
| s_bytes_out | output | SB_W | Updated byte count |

## Verification
The properties assume that reset is held from time zero and that every input is a known value at each rising edge. They also assume that `dir_in` at a start-split visit is the direction meant for that split. Beyond these assumptions, they make no claim about how the frame index advances. The stimulus changes inputs only at falling edges and holds reset low from the start. It lets the frame index stall, repeat or skip microframes, so that the completion tests fail on purpose. It also sends illegal handshake codes, and handshakes in states that must ignore them.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

    typedef enum logic [1:0] {
        PS_DO_START    = 2'd0,
        PS_DO_COMPLETE = 2'd1,
        PS_AWAIT_HS    = 2'd2,
        PS_HALTED      = 2'd3
    } ps_state_e;

    localparam logic [2:0] HS_NAK  = 3'd0;
    localparam logic [2:0] HS_ACK  = 3'd1;
    localparam logic [2:0] HS_DATA = 3'd2;
    localparam logic [2:0] HS_ERR  = 3'd3;
    localparam logic [2:0] HS_NYET = 3'd4;

    typedef enum logic [1:0] {
        RSP_RETRY = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_FAIL  = 2'd2
    } rsp_e;

endpackage

// File: rtl/psplit_ubit.sv
// Microframe decode: one-hot current bit, its right-rotated predecessor,
// and the mask of microframes strictly later in the frame.
module psplit_ubit #(
    parameter int UF_N = 8,
    parameter int UF_B = $clog2(UF_N)
) (
    input  logic [UF_B-1:0] uf_idx,
    output logic [UF_N-1:0] ubit,
    output logic [UF_N-1:0] prev_bit,
    output logic [UF_N-1:0] later_mask
);
    logic [UF_N-1:0] shl;

    for (genvar i = 0; i < UF_N; i++) begin : g_bit
        assign ubit[i]     = (uf_idx == UF_B'(i));
        assign prev_bit[i] = ubit[(i + 1) % UF_N];
    end

    assign shl        = {ubit[UF_N-2:0], 1'b0};
    assign later_mask = ~(shl - UF_N'(1));
endmodule

// File: rtl/psplit_tests.sv
// Start-split hit and the three complete-split tests.
module psplit_tests #(
    parameter int UF_N  = 8,
    parameter int TAG_W = 5
) (
    input  logic [UF_N-1:0]  ubit,
    input  logic [UF_N-1:0]  prev_bit,
    input  logic [UF_N-1:0]  later_mask,
    input  logic [UF_N-1:0]  s_mask,
    input  logic [UF_N-1:0]  c_mask,
    input  logic [UF_N-1:0]  c_prog,
    input  logic [TAG_W-1:0] tag_q,
    input  logic [TAG_W-1:0] tag_now,
    output logic             ss_hit,
    output logic             test_a,
    output logic             test_b,
    output logic             test_c,
    output logic             last_cs
);
    assign ss_hit  = |(s_mask & ubit);
    assign test_a  = |(c_mask & ubit);
    assign test_b  = (tag_q == tag_now);
    // a scheduled previous completion must already be recorded
    assign test_c  = ~|(prev_bit & c_mask & ~c_prog);
    assign last_cs = ~|(c_mask & later_mask);
endmodule

// File: rtl/psplit_resp.sv
// Translator handshake classification.
module psplit_resp
    import psplit_pkg::*;
(
    input  logic [2:0] hs_code,
    input  logic       dir_in,
    input  logic       last_cs,
    output rsp_e       rsp
);
    always_comb begin
        rsp = RSP_FAIL;
        unique case (hs_code)
            HS_NAK:  rsp = RSP_RETRY;
            HS_ACK:  rsp = dir_in ? RSP_FAIL : RSP_DONE;
            HS_DATA: rsp = dir_in ? RSP_DONE : RSP_FAIL;
            HS_NYET: rsp = last_cs ? RSP_FAIL : RSP_RETRY;
            default: rsp = RSP_FAIL;
        endcase
    end
endmodule

// File: rtl/psplit_ctrl.sv
module psplit_ctrl
    import psplit_pkg::*;
#(
    parameter int UF_N      = 8,
    parameter int TAG_W     = 5,
    parameter int CERR_W    = 2,
    parameter int CERR_INIT = 3,
    parameter int SB_W      = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            visit,
    input  logic [$clog2(UF_N)+TAG_W-1:0]   fr_idx,
    input  logic [UF_N-1:0]                 s_mask,
    input  logic [UF_N-1:0]                 c_mask,
    input  logic                            dir_in,
    input  logic [SB_W-1:0]                 s_bytes_in,
    input  logic                            hs_valid,
    input  logic [2:0]                      hs_code,
    output logic                            ss_go,
    output logic                            cs_go,
    output logic                            split_err,
    output logic                            split_done,
    output logic [TAG_W-1:0]                frame_tag,
    output logic [UF_N-1:0]                 c_prog,
    output logic [CERR_W-1:0]               cerr,
    output logic [SB_W-1:0]                 s_bytes_out
);
    localparam int UF_B    = $clog2(UF_N);
    localparam int TAG_LSB = UF_B;

    ps_state_e       state_q, state_d;
    logic [UF_N-1:0] ubit, prev_bit, later_mask;
    logic [TAG_W-1:0] tag_now;
    logic            ss_hit, test_a, test_b, test_c, last_cs;
    logic            dir_q, last_q;
    rsp_e            rsp;
    logic            ev_ss, ev_cs, ev_terr, ev_hs;

    assign tag_now = fr_idx[TAG_LSB+TAG_W-1:TAG_LSB];

    psplit_ubit #(.UF_N(UF_N), .UF_B(UF_B)) u_ubit (
        .uf_idx     (fr_idx[UF_B-1:0]),
        .ubit       (ubit),
        .prev_bit   (prev_bit),
        .later_mask (later_mask)
    );

    psplit_tests #(.UF_N(UF_N), .TAG_W(TAG_W)) u_tests (
        .ubit       (ubit),
        .prev_bit   (prev_bit),
        .later_mask (later_mask),
        .s_mask     (s_mask),
        .c_mask     (c_mask),
        .c_prog     (c_prog),
        .tag_q      (frame_tag),
        .tag_now    (tag_now),
        .ss_hit     (ss_hit),
        .test_a     (test_a),
        .test_b     (test_b),
        .test_c     (test_c),
        .last_cs    (last_cs)
    );

    psplit_resp u_resp (
        .hs_code (hs_code),
        .dir_in  (dir_q),
        .last_cs (last_q),
        .rsp     (rsp)
    );

    assign ev_ss   = (state_q == PS_DO_START) && visit && ss_hit;
    assign ev_cs   = (state_q == PS_DO_COMPLETE) && visit && test_a && test_b && test_c;
    assign ev_terr = (state_q == PS_DO_COMPLETE) && visit && test_a && !(test_b && test_c);
    assign ev_hs   = (state_q == PS_AWAIT_HS) && hs_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_DO_START: begin
                if (ev_ss) state_d = PS_DO_COMPLETE;
            end
            PS_DO_COMPLETE: begin
                if (ev_cs) state_d = PS_AWAIT_HS;
            end
            PS_AWAIT_HS: begin
                if (hs_valid) begin
                    unique case (rsp)
                        RSP_RETRY: state_d = PS_DO_COMPLETE;
                        RSP_DONE:  state_d = PS_DO_START;
                        RSP_FAIL:  state_d = (cerr == CERR_W'(1)) ? PS_HALTED : PS_DO_START;
                    endcase
                end
            end
            PS_HALTED: state_d = PS_HALTED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_DO_START;
        else        state_q <= state_d;
    end

    // outputs and tracking fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_go       <= 1'b0;
            cs_go       <= 1'b0;
            split_err   <= 1'b0;
            split_done  <= 1'b0;
            frame_tag   <= '0;
            c_prog      <= '0;
            cerr        <= CERR_W'(CERR_INIT);
            s_bytes_out <= '0;
            dir_q       <= 1'b0;
            last_q      <= 1'b0;
        end else begin
            ss_go      <= 1'b0;
            cs_go      <= 1'b0;
            split_err  <= 1'b0;
            split_done <= 1'b0;
            if (ev_ss) begin
                ss_go       <= 1'b1;
                frame_tag   <= tag_now;
                c_prog      <= '0;
                s_bytes_out <= dir_in ? '0 : s_bytes_in;
                dir_q       <= dir_in;
            end
            if (ev_cs) begin
                cs_go  <= 1'b1;
                c_prog <= c_prog | ubit;
                last_q <= last_cs;
            end
            if (ev_terr) split_err <= 1'b1;
            if (ev_hs) begin
                if (rsp == RSP_DONE) split_done <= 1'b1;
                if (rsp == RSP_FAIL) cerr <= cerr - CERR_W'(1);
            end
        end
    end
endmodule

// File: rtl/psplit_chk.sv
module psplit_chk #(
    parameter int UF_N   = 8,
    parameter int CERR_W = 2,
    parameter int SB_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              visit,
    input logic              dir_in,
    input logic              ss_go,
    input logic              cs_go,
    input logic              split_err,
    input logic              split_done,
    input logic [UF_N-1:0]   c_prog,
    input logic [CERR_W-1:0] cerr,
    input logic [SB_W-1:0]   s_bytes_out
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_go, cs_go, split_err, split_done})); // R13
    AST_SS_AFTER_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
        ss_go |-> $past(visit)); // R1
    AST_SS_IN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_go && $past(dir_in)) |-> (s_bytes_out == '0)); // R2
    AST_SS_PROG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ss_go |-> (c_prog == '0)); // R3
    AST_SS_CERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_go || cs_go) |-> (cerr == $past(cerr))); // R4
    AST_CS_PROG_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_go |-> (((c_prog & $past(c_prog)) == $past(c_prog)) && (c_prog != '0))); // R5
    AST_ERR_HOLDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        split_err |-> $stable(c_prog)); // R7
    AST_CERR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cerr <= $past(cerr)); // R9
    AST_ZERO_CERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cerr == '0) |-> (!ss_go && !cs_go)); // R10
endmodule

bind psplit_ctrl psplit_chk #(.UF_N(UF_N), .CERR_W(CERR_W), .SB_W(SB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .visit       (visit),
    .dir_in      (dir_in),
    .ss_go       (ss_go),
    .cs_go       (cs_go),
    .split_err   (split_err),
    .split_done  (split_done),
    .c_prog      (c_prog),
    .cerr        (cerr),
    .s_bytes_out (s_bytes_out)
);

// File: tb/sim_psplit_ctrl.sv
module sim_psplit_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        visit = 1'b0;
    logic [7:0]  fr_idx = '0;
    logic [7:0]  s_mask = '0;
    logic [7:0]  c_mask = '0;
    logic        dir_in = 1'b0;
    logic [11:0] s_bytes_in = '0;
    logic        hs_valid = 1'b0;
    logic [2:0]  hs_code = '0;
    logic        ss_go, cs_go, split_err, split_done;
    logic [4:0]  frame_tag;
    logic [7:0]  c_prog;
    logic [1:0]  cerr;
    logic [11:0] s_bytes_out;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    // reference model state
    int m_st, m_tag, m_cprog, m_cerr, m_sb;
    bit m_dir, m_last, m_ss, m_cs, m_err, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    psplit_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .visit(visit), .fr_idx(fr_idx),
        .s_mask(s_mask), .c_mask(c_mask), .dir_in(dir_in),
        .s_bytes_in(s_bytes_in), .hs_valid(hs_valid), .hs_code(hs_code),
        .ss_go(ss_go), .cs_go(cs_go), .split_err(split_err),
        .split_done(split_done), .frame_tag(frame_tag), .c_prog(c_prog),
        .cerr(cerr), .s_bytes_out(s_bytes_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_fail();
        m_cerr = m_cerr - 1;
        m_st = (m_cerr == 0) ? 3 : 0;
    endtask

    task automatic model_edge();
        int uf, tn, p;
        bit a, b, c;
        m_ss = 0; m_cs = 0; m_err = 0; m_done = 0;
        if (!rst_n) begin
            m_st = 0; m_tag = 0; m_cprog = 0; m_cerr = 3; m_sb = 0;
            m_dir = 0; m_last = 0;
            return;
        end
        uf = int'(fr_idx) % 8;
        tn = int'(fr_idx) / 8;
        case (m_st)
            0: if (visit && s_mask[uf]) begin
                m_ss = 1; m_tag = tn; m_cprog = 0;
                m_sb = dir_in ? 0 : int'(s_bytes_in);
                m_dir = dir_in; m_st = 1;
            end
            1: if (visit) begin
                p = (uf + 7) % 8;
                a = c_mask[uf];
                b = (m_tag == tn);
                c = !c_mask[p] || m_cprog[p];
                if (a && b && c) begin
                    m_cs = 1; m_cprog = m_cprog | (1 << uf);
                    m_last = ((int'(c_mask) >> (uf + 1)) == 0);
                    m_st = 2;
                end else if (a) m_err = 1;
            end
            2: if (hs_valid) begin
                case (int'(hs_code))
                    0: m_st = 1;
                    1: if (!m_dir) begin m_done = 1; m_st = 0; end else model_fail();
                    2: if (m_dir) begin m_done = 1; m_st = 0; end else model_fail();
                    4: if (m_last) model_fail(); else m_st = 1;
                    default: model_fail();
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        chk("R1 ss_go", ss_go, m_ss);
        chk("R2 s_bytes_out", s_bytes_out, m_sb);
        chk("R3 frame_tag", frame_tag, m_tag);
        chk("R5 c_prog", c_prog, m_cprog);
        chk("R5 cs_go", cs_go, m_cs);
        chk("R7 split_err", split_err, m_err);
        chk("R8 split_done", split_done, m_done);
        chk("R9 cerr", cerr, m_cerr);
        if (m_ss || m_cs) chk("R4 cerr kept on issue", cerr, m_cerr);
        chk("R13 pulse exclusivity", int'($countones({ss_go, cs_go, split_err, split_done}) <= 1), 1);
    endtask

    task automatic step(input bit v, input int fi, input int sm, input int cm,
                        input bit din, input int sb, input bit hv, input int hc);
        visit = v; fr_idx = 8'(fi); s_mask = 8'(sm); c_mask = 8'(cm);
        dir_in = din; s_bytes_in = 12'(sb); hs_valid = hv; hs_code = 3'(hc);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int fi, sm, cm, k;
        bit din;
        @(negedge clk);
        do_reset();
        chk("R12 ss_go after reset", ss_go, 0);
        chk("R12 cs_go after reset", cs_go, 0);
        chk("R12 cerr after reset", cerr, 3);
        chk("R12 c_prog after reset", c_prog, 0);
        chk("R12 frame_tag after reset", frame_tag, 0);
        chk("R12 s_bytes_out after reset", s_bytes_out, 0);

        // OUT split, frame 2
        step(1, 16, 'h01, 'h1C, 0, 'h2A, 0, 0);
        chk("R1 start-split issued", ss_go, 1);
        chk("R3 tag of frame 2", frame_tag, 2);
        chk("R2 OUT keeps bytes", s_bytes_out, 'h2A);
        step(1, 17, 'h01, 'h1C, 0, 'h2A, 0, 0);
        chk("R5 no complete when test A fails", cs_go, 0);
        step(1, 18, 'h01, 'h1C, 0, 'h2A, 0, 0);
        chk("R5 complete-split issued", cs_go, 1);
        step(0, 18, 'h01, 'h1C, 0, 'h2A, 1, 0);
        step(1, 19, 'h01, 'h1C, 0, 'h2A, 0, 0);
        chk("R8 NAK leads to next complete", cs_go, 1);
        step(0, 19, 'h01, 'h1C, 0, 'h2A, 1, 1);
        chk("R8 ACK on OUT finishes", split_done, 1);
        step(0, 20, 'h01, 'h1C, 0, 'h2A, 1, 3);
        chk("R11 handshake in start state ignored", cerr, 3);

        // IN split, wrap of the previous bit
        step(1, 24, 'h01, 'h81, 1, 'h55, 0, 0);
        chk("R2 IN clears bytes", s_bytes_out, 0);
        step(1, 24, 'h01, 'h81, 1, 'h55, 0, 0);
        chk("R6 microframe 0 checks bit 7", split_err, 1);
        chk("R6 no complete on wrap failure", cs_go, 0);
        step(1, 31, 'h01, 'h81, 1, 'h55, 0, 0);
        chk("R5 complete at microframe 7", cs_go, 1);
        step(1, 32, 'h01, 'h81, 1, 'h55, 0, 0);
        chk("R11 visit while awaiting ignored", int'(cs_go | split_err | ss_go), 0);
        step(0, 32, 'h01, 'h81, 1, 'h55, 1, 4);
        chk("R9 NYET on last costs budget", cerr, 2);

        // NYET not last, then ERR
        step(1, 40, 'h01, 'h06, 0, 'h10, 0, 0);
        step(1, 41, 'h01, 'h06, 0, 'h10, 0, 0);
        step(0, 41, 'h01, 'h06, 0, 'h10, 1, 4);
        chk("R9 NYET not last keeps budget", cerr, 2);
        step(1, 42, 'h01, 'h06, 0, 'h10, 0, 0);
        chk("R5 second complete after NYET", cs_go, 1);
        step(0, 42, 'h01, 'h06, 0, 'h10, 1, 3);
        chk("R9 ERR costs budget", cerr, 1);
        step(1, 48, 'h01, 'h02, 0, 'h10, 0, 0);
        step(1, 49, 'h01, 'h02, 0, 'h10, 0, 0);
        step(0, 49, 'h01, 'h02, 0, 'h10, 1, 2);
        chk("R10 budget exhausted", cerr, 0);
        step(1, 56, 'hFF, 'hFF, 0, 'h10, 0, 0);
        chk("R10 halted issues nothing", int'(ss_go | cs_go), 0);

        // randomized episodes
        for (int ep = 0; ep < 40; ep++) begin
            do_reset();
            fi = int'($urandom % 256);
            k = int'($urandom % 8);
            sm = 1 << k;
            cm = ((1 << ((k + 2) % 8)) | (1 << ((k + 3) % 8)) | (1 << ((k + 4) % 8)));
            din = 1'($urandom % 2);
            for (int cyc = 0; cyc < 300; cyc++) begin
                bit hv;
                int hc;
                if ($urandom % 20 == 0) begin
                    k = int'($urandom % 8);
                    sm = 1 << k;
                    cm = ($urandom % 4 == 0) ? int'($urandom % 256)
                       : ((1 << ((k + 1) % 8)) | (1 << ((k + 2) % 8)) | (1 << ((k + 3) % 8)));
                    if (m_st == 0) din = 1'($urandom % 2);
                end
                hv = (m_st == 2) ? ($urandom % 2 == 0) : ($urandom % 10 == 0);
                hc = ($urandom % 3 == 0) ? 0 : int'($urandom % 8);
                step(1'($urandom % 4 != 0), fi, sm, cm, din, int'($urandom % 4096), hv, hc);
                case ($urandom % 8)
                    0:       ;
                    1:       fi = (fi + 2) % 256;
                    default: fi = (fi + 1) % 256;
                endcase
            end
        end

        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule